// File: doc/BRIEF.md
# Register-Mapped Inter-Pipeline Operand Queues

This block couples an integer pipeline and a floating-point pipeline through two blocking FIFO queues. One queue carries 32-bit values from the integer side to the FP side. The other carries 64-bit values back. Neither pipeline issues explicit queue instructions. Instead, one architectural register number (31) is repurposed while a control bit is set. A writeback to that register pushes into the outgoing queue, and a decode-stage read of it pops from the incoming queue.

Each side sees four things: a writeback port, a decode-stage source-read port, a stall signal for each of the two, and a register-file write enable. The write enable tells the side whether the writeback should land in its own register file. A shared `drained` output reports that both queues are empty. A thread join waits on it before it completes. A single control write port sets and clears the enable bit.

Top module: `xpipe_queue_pair`

## Requirements
- R1: After a synchronous active-high reset, both queues are empty, `drained` is 1, `cfg_en` is 0 and no stall output is high.
- R2: When `cfg_wr_en` is high at a clock edge, `cfg_en` takes the value of `cfg_wr_val` from the next cycle on.
- R3: With `cfg_en` = 1, an integer writeback with destination 31 pushes `i_wb_data` into the integer-to-FP queue and drives `i_rf_we` low. Writebacks to any other destination drive `i_rf_we` high and do not push.
- R4: With `cfg_en` = 1, an FP writeback with destination 31 pushes `f_wb_data` into the FP-to-integer queue and drives `f_rf_we` low. Other destinations drive `f_rf_we` high.
- R5: With `cfg_en` = 1, a decode that names source 31 pops the queue feeding its side. The popped value is on `f_dec_data` or `i_dec_data` in the same cycle, and values come out in push order.
- R6: A pop from an empty queue raises the consumer's decode stall and removes nothing. A push in the same cycle does not bypass to it.
- R7: A push into a full queue raises the producer's writeback stall and is not stored, unless the same queue is popped in that cycle. In that case both the push and the pop succeed.
- R8: A decode that names register 31 in several source fields pops exactly one entry.
- R9: With `cfg_en` = 0, no push, pop or stall occurs. Register 31 writebacks drive the register-file write enable high.
- R10: `drained` is 1 exactly when both queues are empty.
- R11: Each queue keeps push order over sequences far longer than its depth, so its pointers wrap modulo `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the enable bit |
| cfg_wr_val | input | 1 | Value written to the enable bit |
| cfg_en | output | 1 | Current enable bit |
| i_wb_valid | input | 1 | Integer writeback valid |
| i_wb_rd | input | 5 | Integer writeback destination |
| i_wb_data | input | IW | Integer writeback value |
| i_wb_stall | output | 1 | Integer writeback must hold (queue full) |
| i_rf_we | output | 1 | Integer register file write enable |
| i_dec_valid | input | 1 | Integer decode valid |
| i_dec_rs1 | input | 5 | Integer source 1 |
| i_dec_rs2 | input | 5 | Integer source 2 |
| i_dec_stall | output | 1 | Integer decode must hold (queue empty) |
| i_dec_data | output | FW | Value popped for the integer side |
| f_wb_valid | input | 1 | FP writeback valid |
| f_wb_rd | input | 5 | FP writeback destination |
| f_wb_data | input | FW | FP writeback value |
| f_wb_stall | output | 1 | FP writeback must hold (queue full) |
| f_rf_we | output | 1 | FP register file write enable |
| f_dec_valid | input | 1 | FP decode valid |
| f_dec_rs1 | input | 5 | FP source 1 |
| f_dec_rs2 | input | 5 | FP source 2 |
| f_dec_rs3 | input | 5 | FP source 3 |
| f_dec_stall | output | 1 | FP decode must hold (queue empty) |
| f_dec_data | output | IW | Value popped for the FP side |
| drained | output | 1 | Both queues empty |

## Verification
The hardest case to reach is a queue that sits exactly full while its consumer pops in the same cycle that the producer pushes. This must succeed with no stall. The bench fills the integer-to-FP queue with eight accepted writebacks. It then starts a ninth writeback and an FP decode of register 31 from the same falling edge, so both meet the full queue together. A second variant delays the pop by three cycles to hold the producer stalled. The mirror case, an empty queue with a same-cycle push, is created the same way from the empty state.

// File: rtl/xq_pkg.sv
package xq_pkg;
  localparam int REG_W = 5;
  typedef logic [REG_W-1:0] regidx_t;
  localparam regidx_t QUEUE_REG = regidx_t'(31);
endpackage

// File: rtl/xq_srcmatch.sv
module xq_srcmatch #(
  parameter int NSRC = 2
) (
  input  logic [NSRC*xq_pkg::REG_W-1:0] srcs,
  output logic                          hit
);
  logic [NSRC-1:0] each;
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign each[g] = (srcs[g*xq_pkg::REG_W +: xq_pkg::REG_W] == xq_pkg::QUEUE_REG);
  end
  assign hit = |each;
endmodule

// File: rtl/xq_fifo.sv
module xq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/xpipe_queue_pair.sv
module xpipe_queue_pair #(
  parameter int DEPTH = 8,
  parameter int IW    = 32,
  parameter int FW    = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_wr_en,
  input  logic                     cfg_wr_val,
  output logic                     cfg_en,
  input  logic                     i_wb_valid,
  input  logic [xq_pkg::REG_W-1:0] i_wb_rd,
  input  logic [IW-1:0]            i_wb_data,
  output logic                     i_wb_stall,
  output logic                     i_rf_we,
  input  logic                     i_dec_valid,
  input  logic [xq_pkg::REG_W-1:0] i_dec_rs1,
  input  logic [xq_pkg::REG_W-1:0] i_dec_rs2,
  output logic                     i_dec_stall,
  output logic [FW-1:0]            i_dec_data,
  input  logic                     f_wb_valid,
  input  logic [xq_pkg::REG_W-1:0] f_wb_rd,
  input  logic [FW-1:0]            f_wb_data,
  output logic                     f_wb_stall,
  output logic                     f_rf_we,
  input  logic                     f_dec_valid,
  input  logic [xq_pkg::REG_W-1:0] f_dec_rs1,
  input  logic [xq_pkg::REG_W-1:0] f_dec_rs2,
  input  logic [xq_pkg::REG_W-1:0] f_dec_rs3,
  output logic                     f_dec_stall,
  output logic [IW-1:0]            f_dec_data,
  output logic                     drained
);
  import xq_pkg::*;

  logic en_q;
  always_ff @(posedge clk) begin
    if (rst)            en_q <= 1'b0;
    else if (cfg_wr_en) en_q <= cfg_wr_val;
  end
  assign cfg_en = en_q;

  logic i_hit, f_hit;
  xq_srcmatch #(.NSRC(2)) u_imatch (.srcs({i_dec_rs2, i_dec_rs1}), .hit(i_hit));
  xq_srcmatch #(.NSRC(3)) u_fmatch (.srcs({f_dec_rs3, f_dec_rs2, f_dec_rs1}), .hit(f_hit));

  logic i_push_req, f_push_req, i_pop_req, f_pop_req;
  assign i_push_req = en_q && i_wb_valid && (i_wb_rd == QUEUE_REG);
  assign f_push_req = en_q && f_wb_valid && (f_wb_rd == QUEUE_REG);
  assign i_pop_req  = en_q && i_dec_valid && i_hit;
  assign f_pop_req  = en_q && f_dec_valid && f_hit;

  logic          i2f_push, i2f_pop, i2f_full, i2f_empty;
  logic          f2i_push, f2i_pop, f2i_full, f2i_empty;
  logic [CW-1:0] i2f_count, f2i_count;

  assign i2f_pop  = f_pop_req && !i2f_empty;
  assign i2f_push = i_push_req && (!i2f_full || i2f_pop);
  assign f2i_pop  = i_pop_req && !f2i_empty;
  assign f2i_push = f_push_req && (!f2i_full || f2i_pop);

  xq_fifo #(.W(IW), .DEPTH(DEPTH)) u_i2f (
    .clk(clk), .rst(rst), .push(i2f_push), .pop(i2f_pop), .din(i_wb_data),
    .dout(f_dec_data), .full(i2f_full), .empty(i2f_empty), .count(i2f_count)
  );

  xq_fifo #(.W(FW), .DEPTH(DEPTH)) u_f2i (
    .clk(clk), .rst(rst), .push(f2i_push), .pop(f2i_pop), .din(f_wb_data),
    .dout(i_dec_data), .full(f2i_full), .empty(f2i_empty), .count(f2i_count)
  );

  assign i_wb_stall  = i_push_req && !i2f_push;
  assign f_wb_stall  = f_push_req && !f2i_push;
  assign i_dec_stall = i_pop_req && !f2i_pop;
  assign f_dec_stall = f_pop_req && !i2f_pop;
  assign i_rf_we     = i_wb_valid && !i_push_req;
  assign f_rf_we     = f_wb_valid && !f_push_req;
  assign drained     = i2f_empty && f2i_empty;
endmodule

// File: rtl/xq_checker.sv
module xq_checker #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_en,
  input logic                     i_dec_valid,
  input logic [xq_pkg::REG_W-1:0] i_dec_rs1,
  input logic [xq_pkg::REG_W-1:0] i_dec_rs2,
  input logic                     i_wb_stall,
  input logic                     i_dec_stall,
  input logic                     f_wb_stall,
  input logic                     f_dec_stall,
  input logic [CW-1:0]            i2f_count,
  input logic [CW-1:0]            f2i_count,
  input logic                     drained
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |-> !(i_wb_stall || i_dec_stall || f_wb_stall || f_dec_stall)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (int'(i2f_count) <= DEPTH) && (int'(f2i_count) <= DEPTH)); // R7
  AST_FULL_ONLY_STALL: assert property (@(posedge clk) disable iff (rst)
    i_wb_stall |-> (int'(i2f_count) == DEPTH)); // R7
  AST_EMPTY_POP_STALL: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && i_dec_valid && (f2i_count == '0) &&
     ((i_dec_rs1 == xq_pkg::QUEUE_REG) || (i_dec_rs2 == xq_pkg::QUEUE_REG))) |-> i_dec_stall); // R6
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((int'(i2f_count) <= int'($past(i2f_count)) + 1) &&
              (int'(i2f_count) + 1 >= int'($past(i2f_count))))); // R8
  AST_DRAINED_NO_PUSH_STALL: assert property (@(posedge clk) disable iff (rst)
    drained |-> !(i_wb_stall || f_wb_stall)); // R10
endmodule

bind xpipe_queue_pair xq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .i_dec_valid(i_dec_valid),
  .i_dec_rs1(i_dec_rs1), .i_dec_rs2(i_dec_rs2), .i_wb_stall(i_wb_stall),
  .i_dec_stall(i_dec_stall), .f_wb_stall(f_wb_stall), .f_dec_stall(f_dec_stall),
  .i2f_count(i2f_count), .f2i_count(f2i_count), .drained(drained)
);

// File: tb/sim_xpipe_queue_pair.sv
module sim_xpipe_queue_pair;
  localparam int DEPTH = 8;
  localparam int IW = 32;
  localparam int FW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr_en = 0, cfg_wr_val = 0, cfg_en;
  logic i_wb_valid = 0; logic [4:0] i_wb_rd = 0; logic [IW-1:0] i_wb_data = 0;
  logic i_wb_stall, i_rf_we;
  logic i_dec_valid = 0; logic [4:0] i_dec_rs1 = 0, i_dec_rs2 = 0;
  logic i_dec_stall; logic [FW-1:0] i_dec_data;
  logic f_wb_valid = 0; logic [4:0] f_wb_rd = 0; logic [FW-1:0] f_wb_data = 0;
  logic f_wb_stall, f_rf_we;
  logic f_dec_valid = 0; logic [4:0] f_dec_rs1 = 0, f_dec_rs2 = 0, f_dec_rs3 = 0;
  logic f_dec_stall; logic [IW-1:0] f_dec_data;
  logic drained;

  always #10 clk = ~clk;

  xpipe_queue_pair #(.DEPTH(DEPTH), .IW(IW), .FW(FW)) u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard model
  logic [IW-1:0] q_i2f[$];
  logic [FW-1:0] q_f2i[$];
  bit en_m = 0;
  int n_i2f_pops = 0, n_f2i_pops = 0;

  initial forever begin
    @(negedge clk); #8;
    if (rst) begin
      q_i2f.delete(); q_f2i.delete(); en_m = 0;
    end else begin
      bit ipw, fpw, ipr, fpr, i2f_pop, i2f_push, f2i_pop, f2i_push;
      int fh, ih;
      fh = int'(f_dec_rs1 == 31) + int'(f_dec_rs2 == 31) + int'(f_dec_rs3 == 31);
      ih = int'(i_dec_rs1 == 31) + int'(i_dec_rs2 == 31);
      chk(cfg_en == en_m, "R2", 64'(cfg_en), 64'(en_m));
      ipw = en_m && i_wb_valid && (i_wb_rd == 31);
      fpw = en_m && f_wb_valid && (f_wb_rd == 31);
      ipr = en_m && i_dec_valid && (ih > 0);
      fpr = en_m && f_dec_valid && (fh > 0);
      i2f_pop  = fpr && (q_i2f.size() > 0);
      i2f_push = ipw && ((q_i2f.size() < DEPTH) || i2f_pop);
      f2i_pop  = ipr && (q_f2i.size() > 0);
      f2i_push = fpw && ((q_f2i.size() < DEPTH) || f2i_pop);
      if (i_wb_valid) chk(i_rf_we == !ipw, en_m ? "R3" : "R9", 64'(i_rf_we), 64'(!ipw));
      if (f_wb_valid) chk(f_rf_we == !fpw, en_m ? "R4" : "R9", 64'(f_rf_we), 64'(!fpw));
      if (i_wb_valid) chk(i_wb_stall == (ipw && !i2f_push), en_m ? "R7" : "R9", 64'(i_wb_stall), 64'(ipw && !i2f_push));
      if (f_wb_valid) chk(f_wb_stall == (fpw && !f2i_push), en_m ? "R7" : "R9", 64'(f_wb_stall), 64'(fpw && !f2i_push));
      if (f_dec_valid) chk(f_dec_stall == (fpr && !i2f_pop), en_m ? "R6" : "R9", 64'(f_dec_stall), 64'(fpr && !i2f_pop));
      if (i_dec_valid) chk(i_dec_stall == (ipr && !f2i_pop), en_m ? "R6" : "R9", 64'(i_dec_stall), 64'(ipr && !f2i_pop));
      if (i2f_pop) begin
        chk(f_dec_data == q_i2f[0], (fh > 1) ? "R8" : "R5", 64'(f_dec_data), 64'(q_i2f[0]));
        void'(q_i2f.pop_front()); n_i2f_pops++;
      end
      if (f2i_pop) begin
        chk(i_dec_data == q_f2i[0], (ih > 1) ? "R8" : "R5", i_dec_data, q_f2i[0]);
        void'(q_f2i.pop_front()); n_f2i_pops++;
      end
      if (i2f_push) q_i2f.push_back(i_wb_data);
      if (f2i_push) q_f2i.push_back(f_wb_data);
      if (cfg_wr_en) en_m = cfg_wr_val;
    end
  end

  // Driver tasks: entered at a falling edge, return at a falling edge
  task automatic put_int(input logic [4:0] rd, input logic [IW-1:0] d);
    bit s;
    i_wb_valid = 1; i_wb_rd = rd; i_wb_data = d;
    do begin #8; s = i_wb_stall; @(negedge clk); end while (s);
    i_wb_valid = 0;
  endtask

  task automatic put_fp(input logic [4:0] rd, input logic [FW-1:0] d);
    bit s;
    f_wb_valid = 1; f_wb_rd = rd; f_wb_data = d;
    do begin #8; s = f_wb_stall; @(negedge clk); end while (s);
    f_wb_valid = 0;
  endtask

  task automatic get_fp(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c);
    bit s;
    f_dec_valid = 1; f_dec_rs1 = a; f_dec_rs2 = b; f_dec_rs3 = c;
    do begin #8; s = f_dec_stall; @(negedge clk); end while (s);
    f_dec_valid = 0;
  endtask

  task automatic get_int(input logic [4:0] a, input logic [4:0] b);
    bit s;
    i_dec_valid = 1; i_dec_rs1 = a; i_dec_rs2 = b;
    do begin #8; s = i_dec_stall; @(negedge clk); end while (s);
    i_dec_valid = 0;
  endtask

  task automatic set_en(input bit v);
    cfg_wr_en = 1; cfg_wr_val = v;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #8;
    chk(drained === 1'b1, "R1", 64'(drained), 64'd1);
    chk(cfg_en === 1'b0, "R1", 64'(cfg_en), 64'd0);
    chk({i_wb_stall, i_dec_stall, f_wb_stall, f_dec_stall} === 4'b0, "R1",
        64'({i_wb_stall, i_dec_stall, f_wb_stall, f_dec_stall}), 64'd0);
    @(negedge clk);

    // R9: register 31 is ordinary while disabled
    put_int(31, 32'h1111_0000);
    get_fp(31, 31, 0);
    #8; chk(drained === 1'b1, "R9", 64'(drained), 64'd1);
    @(negedge clk);

    set_en(1);
    put_int(5, 32'h0000_0005);  // R3 ordinary destination

    // R6: pop from empty meets a same-cycle push
    fork
      put_int(31, 32'hA1A1_0001);
      get_fp(31, 0, 0);
    join

    // R7: fill, then push and pop together on a full queue
    for (int k = 0; k < DEPTH; k++) put_int(31, 32'h100 + 32'(k));
    #8; chk(drained === 1'b0, "R10", 64'(drained), 64'd0);
    @(negedge clk);
    fork
      put_int(31, 32'h0000_0999);
      get_fp(0, 31, 0);
    join
    // R7: held stall on full until a delayed pop
    fork
      put_int(31, 32'h0000_0777);
      begin repeat (3) @(negedge clk); get_fp(31, 0, 31); end
    join
    for (int k = 0; k < DEPTH; k++) get_fp((k % 2) ? 5'd31 : 5'd2, 5'd31, 5'd31);

    // R11: long streams wrap the pointers
    base = n_i2f_pops;
    fork
      for (int k = 0; k < 3 * DEPTH; k++) put_int(31, 32'hC000_0000 + 32'(k * 7));
      for (int k = 0; k < 3 * DEPTH; k++) begin
        repeat (k % 3) @(negedge clk);
        get_fp(31, 0, 0);
      end
    join
    chk(n_i2f_pops - base == 3 * DEPTH, "R11", 64'(n_i2f_pops - base), 64'(3 * DEPTH));

    // R4 / R5 / R8 on the FP-to-integer queue
    put_fp(3, 64'h3);
    base = n_f2i_pops;
    fork
      for (int k = 0; k < 3 * DEPTH; k++) put_fp(31, {32'hF00D_0000 + 32'(k), 32'(k * 13)});
      for (int k = 0; k < 3 * DEPTH; k++) begin
        repeat ((k + 1) % 4) @(negedge clk);
        get_int((k % 3 == 0) ? 5'd31 : 5'd1, 5'd31);
      end
    join
    chk(n_f2i_pops - base == 3 * DEPTH, "R11", 64'(n_f2i_pops - base), 64'(3 * DEPTH));

    // R10: drained after everything consumed
    @(negedge clk); #8;
    chk(drained === 1'b1, "R10", 64'(drained), 64'd1);
    @(negedge clk);

    // R2 / R9: disable again, writeback to 31 hits the register file
    set_en(0);
    put_fp(31, 64'hDEAD);
    #8; chk(drained === 1'b1, "R9", 64'(drained), 64'd1);
    @(negedge clk);
    repeat (2) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R5 watchdog expired actual=hung expected=progress");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule